// File: doc/BRIEF.md
# Warp Instruction Buffer with Register Scoreboard

This block sits between the fetch stage and the issue stage of one warp. Fetched instructions are queued in a small in-order buffer. Each instruction carries only what the hazard check needs: an opaque tag, one destination register ID and two source register IDs, each with its own enable bit. A short scoreboard holds the IDs of registers whose writes are still in flight. The instruction at the head of the buffer may leave only when none of its enabled register IDs matches a pending entry. When it issues, its destination is recorded in the scoreboard. A later writeback of that register frees the entry again.

The buffer refuses fetches while it is full, so the fetch stage has to stall or fetch again later. Issue is strictly in order. A head that is held blocks every instruction behind it. A writeback is applied before the hazard check in the same cycle, so a waiting instruction can issue in the cycle its blocking register is written back. One instance serves one warp. A core places one instance beside each of its warps.

Top module: `wsb_ibuf`

## Requirements
- R1: After reset the buffer and the scoreboard are empty: `fetch_ready` is 1 and `issue_valid` is 0.
- R2: `fetch_ready` is 0 exactly when the buffer holds DEPTH instructions. A fetch offered while it is 0 is not stored.
- R3: Instructions leave in the order they were accepted, with the tag, register IDs and enable bits they carried. `issue_valid` is 0 while the buffer is empty.
- R4: An instruction accepted into an empty buffer with no hazard shows `issue_valid` = 1 in the cycle after it was accepted.
- R5: While a source field whose enable is 1 matches a pending scoreboard entry, the head does not issue (read-after-write).
- R6: While a destination field whose enable is 1 matches a pending scoreboard entry, the head does not issue (write-after-write).
- R7: A register field whose enable bit is 0 takes no part in the hazard check.
- R8: When every scoreboard entry is pending and the head has its destination enabled, the head does not issue. A head with no enabled destination is not held by this condition.
- R9: Issuing an instruction with an enabled destination records that register as pending from the next cycle on. A writeback clears the matching entry, and an instruction blocked only by that register shows `issue_valid` = 1 in the same cycle as the writeback.
- R10: A writeback of a register ID that is not pending leaves the scoreboard unchanged.
- R11: While `issue_valid` is 1 and `issue_ready` is 0, the head stays offered with unchanged fields.
- R12: A blocked head blocks every younger instruction. The issue port shows the head's fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched instruction is offered |
| fetch_ready | output | 1 | The buffer has room; the offer is taken on this edge |
| fetch_tag | input | TAG_W | Opaque instruction tag |
| fetch_dst | input | REG_W | Destination register ID |
| fetch_dst_en | input | 1 | Destination is written |
| fetch_src_a | input | REG_W | First source register ID |
| fetch_src_a_en | input | 1 | First source is read |
| fetch_src_b | input | REG_W | Second source register ID |
| fetch_src_b_en | input | 1 | Second source is read |
| issue_valid | output | 1 | The head is free of hazards and may issue |
| issue_ready | input | 1 | The issue stage takes the head on this edge |
| issue_tag | output | TAG_W | Tag of the head |
| issue_dst | output | REG_W | Destination ID of the head |
| issue_dst_en | output | 1 | Destination enable of the head |
| issue_src_a | output | REG_W | First source ID of the head |
| issue_src_a_en | output | 1 | First source enable of the head |
| issue_src_b | output | REG_W | Second source ID of the head |
| issue_src_b_en | output | 1 | Second source enable of the head |
| wb_valid | input | 1 | A register write completes |
| wb_reg | input | REG_W | Register ID being written back |

## Verification
Acceptance, scoreboard allocation and scoreboard clearing are registered. A fetch therefore becomes visible at the issue port one edge after it is taken, and an issued destination blocks from the next cycle on. The effect of a writeback on `issue_valid` is combinational and is due in the same cycle. The bench drives every input one time unit after a rising edge. It reads `issue_valid` and the fields after they settle in that same cycle, both while a writeback is held and after the edge that commits it. It sweeps every pair of pending and probed register IDs for each of the three register fields.

// File: rtl/wsb_pkg.sv
`timescale 1ns/1ps
package wsb_pkg;
   // Reason the head of the buffer is not offered for issue.
   typedef enum logic [2:0] {
      HZ_NONE   = 3'd0,
      HZ_EMPTY  = 3'd1,
      HZ_RAW    = 3'd2,
      HZ_WAW    = 3'd3,
      HZ_NOSLOT = 3'd4
   } hz_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/wsb_fifo.sv
`timescale 1ns/1ps
module wsb_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PW = wsb_pkg::idx_w(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;

   generate
      if (POW2) begin : g_pow2
         // pointers wrap by overflow
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   assign dout  = mem[rd_ptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/wsb_scoreboard.sv
`timescale 1ns/1ps
module wsb_scoreboard #(
   parameter int unsigned REG_W   = 5,
   parameter int unsigned ENTRIES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wb_valid,
   input  logic [REG_W-1:0]           wb_reg,
   input  logic                       alloc,
   input  logic [REG_W-1:0]           alloc_reg,
   input  logic [REG_W-1:0]           q_dst,
   input  logic                       q_dst_en,
   input  logic [REG_W-1:0]           q_src_a,
   input  logic                       q_src_a_en,
   input  logic [REG_W-1:0]           q_src_b,
   input  logic                       q_src_b_en,
   output logic                       src_hit,
   output logic                       dst_hit,
   output logic                       no_slot,
   output logic [ENTRIES-1:0]         ent_valid,
   output logic [ENTRIES*REG_W-1:0]   ent_ids
);
   localparam int unsigned IW = wsb_pkg::idx_w(ENTRIES);

   logic [REG_W-1:0]   id_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q, live, hit_a, hit_b, hit_d;
   logic [IW-1:0]      free_idx;

   // Writeback is folded in before any comparison.
   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
         assign live[e]  = vld_q[e] && !(wb_valid && id_q[e] == wb_reg);
         assign hit_a[e] = live[e] && q_src_a_en && (id_q[e] == q_src_a);
         assign hit_b[e] = live[e] && q_src_b_en && (id_q[e] == q_src_b);
         assign hit_d[e] = live[e] && q_dst_en   && (id_q[e] == q_dst);
         assign ent_ids[e*REG_W +: REG_W] = id_q[e];
      end
   endgenerate

   assign src_hit   = |(hit_a | hit_b);
   assign dst_hit   = |hit_d;
   assign no_slot   = &live;
   assign ent_valid = vld_q;

   // lowest free entry wins
   always_comb begin
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!live[i]) free_idx = IW'(i);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < ENTRIES; i++) id_q[i] <= '0;
      end else begin
         vld_q <= live;
         if (alloc && !no_slot) begin
            vld_q[free_idx] <= 1'b1;
            id_q[free_idx]  <= alloc_reg;
         end
      end
   end
endmodule

// File: rtl/wsb_ibuf.sv
`timescale 1ns/1ps
module wsb_ibuf #(
   parameter int unsigned REG_W      = 5,
   parameter int unsigned TAG_W      = 16,
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned SB_ENTRIES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_valid,
   output logic             fetch_ready,
   input  logic [TAG_W-1:0] fetch_tag,
   input  logic [REG_W-1:0] fetch_dst,
   input  logic             fetch_dst_en,
   input  logic [REG_W-1:0] fetch_src_a,
   input  logic             fetch_src_a_en,
   input  logic [REG_W-1:0] fetch_src_b,
   input  logic             fetch_src_b_en,
   output logic             issue_valid,
   input  logic             issue_ready,
   output logic [TAG_W-1:0] issue_tag,
   output logic [REG_W-1:0] issue_dst,
   output logic             issue_dst_en,
   output logic [REG_W-1:0] issue_src_a,
   output logic             issue_src_a_en,
   output logic [REG_W-1:0] issue_src_b,
   output logic             issue_src_b_en,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_reg
);
   import wsb_pkg::*;

   typedef struct packed {
      logic [TAG_W-1:0] tag;
      logic [REG_W-1:0] dst;
      logic             dst_en;
      logic [REG_W-1:0] src_a;
      logic             src_a_en;
      logic [REG_W-1:0] src_b;
      logic             src_b_en;
   } uop_t;

   localparam int unsigned UOP_W = $bits(uop_t);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wsb_ibuf: DEPTH must be at least 2");
      end
      if (SB_ENTRIES < 1 || SB_ENTRIES > 8) begin : g_bad_sb
         $error("wsb_ibuf: SB_ENTRIES must lie in 1..8");
      end
      if (REG_W < 1 || TAG_W < 1) begin : g_bad_w
         $error("wsb_ibuf: REG_W and TAG_W must be positive");
      end
   endgenerate

   uop_t in_uop, head;
   logic full, empty, push, fire;
   logic src_hit, dst_hit, no_slot;
   logic [SB_ENTRIES-1:0]       sb_valid;
   logic [SB_ENTRIES*REG_W-1:0] sb_id;
   hz_e  hz;

   assign in_uop = '{tag: fetch_tag, dst: fetch_dst, dst_en: fetch_dst_en,
                     src_a: fetch_src_a, src_a_en: fetch_src_a_en,
                     src_b: fetch_src_b, src_b_en: fetch_src_b_en};

   assign fetch_ready = !full;
   assign push        = fetch_valid && !full;
   assign fire        = issue_valid && issue_ready;

   wsb_fifo #(.WIDTH(UOP_W), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (fire),
      .din   (in_uop),
      .dout  (head),
      .full  (full),
      .empty (empty)
   );

   wsb_scoreboard #(.REG_W(REG_W), .ENTRIES(SB_ENTRIES)) u_sb (
      .clk        (clk),
      .rst_n      (rst_n),
      .wb_valid   (wb_valid),
      .wb_reg     (wb_reg),
      .alloc      (fire && head.dst_en),
      .alloc_reg  (head.dst),
      .q_dst      (head.dst),
      .q_dst_en   (head.dst_en),
      .q_src_a    (head.src_a),
      .q_src_a_en (head.src_a_en),
      .q_src_b    (head.src_b),
      .q_src_b_en (head.src_b_en),
      .src_hit    (src_hit),
      .dst_hit    (dst_hit),
      .no_slot    (no_slot),
      .ent_valid  (sb_valid),
      .ent_ids    (sb_id)
   );

   always_comb begin
      if (empty)                       hz = HZ_EMPTY;
      else if (src_hit)                hz = HZ_RAW;
      else if (dst_hit)                hz = HZ_WAW;
      else if (head.dst_en && no_slot) hz = HZ_NOSLOT;
      else                             hz = HZ_NONE;
   end

   assign issue_valid    = (hz == HZ_NONE);
   assign issue_tag      = head.tag;
   assign issue_dst      = head.dst;
   assign issue_dst_en   = head.dst_en;
   assign issue_src_a    = head.src_a;
   assign issue_src_a_en = head.src_a_en;
   assign issue_src_b    = head.src_b;
   assign issue_src_b_en = head.src_b_en;
endmodule

// File: rtl/wsb_ibuf_checker.sv
`timescale 1ns/1ps
module wsb_ibuf_checker #(
   parameter int unsigned REG_W      = 5,
   parameter int unsigned TAG_W      = 16,
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned SB_ENTRIES = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        fetch_valid,
   input logic                        fetch_ready,
   input logic                        issue_valid,
   input logic                        issue_ready,
   input logic [TAG_W-1:0]            issue_tag,
   input logic [REG_W-1:0]            issue_dst,
   input logic                        issue_dst_en,
   input logic [REG_W-1:0]            issue_src_a,
   input logic                        issue_src_a_en,
   input logic [REG_W-1:0]            issue_src_b,
   input logic                        issue_src_b_en,
   input logic                        wb_valid,
   input logic [REG_W-1:0]            wb_reg,
   input logic [SB_ENTRIES-1:0]       sb_valid,
   input logic [SB_ENTRIES*REG_W-1:0] sb_id
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] occ;
   logic          fire;
   assign fire = issue_valid && issue_ready;

   // independent occupancy model from the handshakes
   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + CW'(fetch_valid && fetch_ready) - CW'(fire);
   end

   function automatic logic pending(input logic [REG_W-1:0] r);
      logic hit = 1'b0;
      for (int i = 0; i < SB_ENTRIES; i++)
         if (sb_valid[i] && sb_id[i*REG_W +: REG_W] == r) hit = 1'b1;
      return hit;
   endfunction

   function automatic logic pending_now(input logic [REG_W-1:0] r);
      return pending(r) && !(wb_valid && wb_reg == r);
   endfunction

   a_r2_ready_tracks_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ready == (occ != CW'(DEPTH)));

   a_r3_empty_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !issue_valid);

   a_r5_no_raw_issue: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !(issue_src_a_en && pending_now(issue_src_a))
                   && !(issue_src_b_en && pending_now(issue_src_b)));

   a_r6_no_waw_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_dst_en) |-> !pending_now(issue_dst));

   a_r9_dst_recorded: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && issue_dst_en) |=> pending($past(issue_dst)));

   a_r9_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !(fire && issue_dst_en && issue_dst == wb_reg))
         |=> !pending($past(wb_reg)));

   a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> (issue_valid && $stable(issue_tag)));
endmodule

bind wsb_ibuf wsb_ibuf_checker #(
   .REG_W(REG_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .SB_ENTRIES(SB_ENTRIES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_valid    (fetch_valid),
   .fetch_ready    (fetch_ready),
   .issue_valid    (issue_valid),
   .issue_ready    (issue_ready),
   .issue_tag      (issue_tag),
   .issue_dst      (issue_dst),
   .issue_dst_en   (issue_dst_en),
   .issue_src_a    (issue_src_a),
   .issue_src_a_en (issue_src_a_en),
   .issue_src_b    (issue_src_b),
   .issue_src_b_en (issue_src_b_en),
   .wb_valid       (wb_valid),
   .wb_reg         (wb_reg),
   .sb_valid       (sb_valid),
   .sb_id          (sb_id)
);

// File: tb/wsb_ibuf_test.sv
`timescale 1ns/1ps
module wsb_ibuf_test;
   localparam int unsigned REG_W = 3, TAG_W = 8, DEPTH = 4, SB = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fetch_valid = 0, fetch_ready;
   logic [TAG_W-1:0] fetch_tag = '0;
   logic [REG_W-1:0] fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
   logic fetch_dst_en = 0, fetch_src_a_en = 0, fetch_src_b_en = 0;
   logic issue_valid, issue_ready = 0;
   logic [TAG_W-1:0] issue_tag;
   logic [REG_W-1:0] issue_dst, issue_src_a, issue_src_b;
   logic issue_dst_en, issue_src_a_en, issue_src_b_en;
   logic wb_valid = 0;
   logic [REG_W-1:0] wb_reg = '0;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wsb_ibuf #(.REG_W(REG_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .SB_ENTRIES(SB)) uut (.*);

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; fetch_valid = 0; issue_ready = 0; wb_valid = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
   endtask

   // one fetch, taken on the next edge
   task automatic push(input int tag, input int d, input bit de,
                       input int a, input bit ae, input int b, input bit be);
      fetch_valid = 1; fetch_tag = TAG_W'(tag);
      fetch_dst = REG_W'(d); fetch_dst_en = de;
      fetch_src_a = REG_W'(a); fetch_src_a_en = ae;
      fetch_src_b = REG_W'(b); fetch_src_b_en = be;
      @(posedge clk); #1 fetch_valid = 0;
   endtask

   task automatic take(input string req, input int tag);
      #1;
      check(req, issue_valid, 1);
      check(req, issue_tag, tag);
      issue_ready = 1;
      @(posedge clk); #1 issue_ready = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      #1;
      check("R1 fetch_ready", fetch_ready, 1);
      check("R1 issue_valid", issue_valid, 0);

      // R2 fill, refuse, R3 order and fields, R11 stall
      for (int i = 0; i < DEPTH; i++) begin
         check("R2 ready before full", fetch_ready, 1);
         push(10 + i, i, 0, i + 1, 1, i + 2, 0);
         if (i == 0) check("R4 valid one cycle after fetch", issue_valid, 1);
      end
      check("R2 ready when full", fetch_ready, 0);
      fetch_valid = 1; fetch_tag = 8'd99;
      @(posedge clk); #1 fetch_valid = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R11 held valid", issue_valid, 1);
      check("R11 held tag", issue_tag, 10);
      for (int i = 0; i < DEPTH; i++) begin
         #1;
         check("R3 src_a field", issue_src_a, i + 1);
         check("R3 src_a_en field", issue_src_a_en, 1);
         check("R3 src_b_en field", issue_src_b_en, 0);
         take("R3 order", 10 + i);
      end
      #1;
      check("R2 refused fetch not stored", issue_valid, 0);
      check("R2 ready after drain", fetch_ready, 1);

      // R5 R6 R7 sweep: pending p, probed field value r
      for (int kind = 0; kind < 3; kind++) begin
         for (int p = 0; p < (1 << REG_W); p++) begin
            for (int r = 0; r < (1 << REG_W); r++) begin
               do_reset();
               push(1, p, 1, 0, 0, 0, 0);
               take("R4 first issue", 1);
               // disabled fields point at p: R7
               case (kind)
                  0: push(2, p, 0, r, 1, p, 0);
                  1: push(2, p, 0, p, 0, r, 1);
                  default: push(2, r, 1, p, 0, p, 0);
               endcase
               #1;
               check(kind == 2 ? "R6 R7 dst hazard" : "R5 R7 src hazard",
                     issue_valid, (r != p) ? 1 : 0);
               if (r == p) begin
                  wb_valid = 1; wb_reg = REG_W'(p);
                  #1 check("R9 same-cycle release", issue_valid, 1);
                  @(posedge clk); #1 wb_valid = 0;
                  #1 check("R9 stays released", issue_valid, 1);
               end
            end
         end
      end

      // R8 R10 R12 R9 scoreboard full
      do_reset();
      push(20, 1, 1, 0, 0, 0, 0); take("R9 alloc 1", 20);
      push(21, 2, 1, 0, 0, 0, 0); take("R9 alloc 2", 21);
      push(22, 3, 1, 0, 0, 0, 0); take("R9 alloc 3", 22);
      push(23, 0, 0, 5, 1, 6, 1);
      take("R8 no-dst issues when full", 23);
      push(24, 4, 1, 0, 0, 0, 0);
      #1 check("R8 dst blocked when full", issue_valid, 0);
      wb_valid = 1; wb_reg = 3'd7;
      #1 check("R10 unknown wb no release", issue_valid, 0);
      @(posedge clk); #1 wb_valid = 0;
      #1 check("R10 still blocked", issue_valid, 0);
      push(25, 0, 0, 6, 1, 0, 0);
      #1;
      check("R12 younger blocked", issue_valid, 0);
      check("R12 head shown", issue_tag, 24);
      wb_valid = 1; wb_reg = 3'd2; issue_ready = 1;
      #1;
      check("R9 release same cycle", issue_valid, 1);
      check("R9 release tag", issue_tag, 24);
      @(posedge clk); #1 wb_valid = 0; issue_ready = 0;
      take("R12 younger follows", 25);
      push(26, 0, 0, 2, 1, 0, 0);
      take("R9 cleared reg usable", 26);
      push(27, 0, 0, 4, 1, 0, 0);
      #1 check("R9 recorded with same-cycle clear", issue_valid, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule